// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block turns a 48-bit linear address into a physical address. It walks a four-level table hierarchy held in memory, and every table entry is 64 bits wide. A walk starts on a one-cycle start strobe, which carries the root table base, the linear address, a write flag and a switch that allows 1 GiB pages. The walker then reads one 8-byte entry per level through a simple request/valid read port. It checks each entry before it decides whether to go down to the next table or to stop at a leaf.

A single rule handles a leaf at any level. An offset mask starts as 48 ones and loses 9 bits each time an entry is fetched. The same mask serves two purposes: it detects large-page frames that are not aligned to their page size, and it merges the low linear-address bits into the returned physical page address. As a result, 4 KiB, 2 MiB and 1 GiB pages all come from the same datapath.

When the walk ends, a one-cycle done pulse carries either the page frame address, the offset mask and a combined-access value, or a page-fault indication with a 4-bit error code.

Top module: `ptw_top`

## Requirements
- R1: After reset, `mem_req`, `done` and `fault` are low and stay low until a walk is started.
- R2: The walk reads the top table first, at `root_base`. At each level L, counting 3 down to 0, the entry address is the current table base plus ((linear >> (9 + 9*L)) & 0xff8), so every read address is 8-byte aligned.
- R3: At most one read is outstanding. A new `mem_req` is raised only after `mem_rvalid` has returned the previous entry.
- R4: An entry with bit 0 clear ends the walk at once as a not-present fault, and no further reads follow. `fault_code` bit layout: [0] protection, [1] write, [2] user (always 0), [3] reserved-bit. For this fault, bits 0 and 3 are 0 and bit 1 equals `is_write`.
- R5: A present entry at level 0 ends the walk as a 4 KiB page. `phys_addr` = entry & 0x000f_ffff_ffff_f000 and `offset_mask` = 0xfff. Entry bit 7 has no effect at this level.
- R6: A present entry with bit 7 set at level 1 ends the walk as a 2 MiB page. The frame is entry & 0x000f_ffff_ffff_e000, so bit 12 is discarded. `phys_addr` = frame + (linear & 0x1ff000) and `offset_mask` = 0x1fffff.
- R7: A present entry with bit 7 set at level 2 ends the walk as a 1 GiB page when `big_en` is 1. In that case `phys_addr` = frame + (linear & 0x3ffff000) and `offset_mask` = 0x3fffffff. When `big_en` is 0, the same entry is a reserved-bit fault.
- R8: A present entry with bit 7 set at level 3 is always a reserved-bit fault.
- R9: A large-page frame with any bit set under the current offset mask is a reserved-bit fault. Its `fault_code` has bits 0 and 3 set and bit 1 equal to `is_write`.
- R10: On success, `access` equals 3'b110 ANDed with bits [2:0] of every entry read during the walk.
- R11: `done` is high for exactly one cycle, namely the cycle after the `mem_rvalid` that returned the final entry. The result outputs hold until the next `done`.
- R12: A start strobe raised while a walk is in progress has no effect. It issues no extra reads and does not change the current walk.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a walk when the walker is idle |
| root_base | input | 52 | Physical base of the top table (4 KiB aligned) |
| lin_addr | input | 48 | Linear address to translate |
| is_write | input | 1 | Access is a write; reported in the fault code |
| big_en | input | 1 | Allows 1 GiB leaves at level 2 |
| mem_req | output | 1 | One-cycle read request for an 8-byte entry |
| mem_addr | output | 52 | Byte address of the requested entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended in a page fault |
| fault_code | output | 4 | Fault error flags (layout in R4) |
| phys_addr | output | 52 | Page-aligned physical address of the translation |
| offset_mask | output | 48 | Mask of the linear bits that pass through unchanged |
| access | output | 3 | Combined access bits of the walk |

## Verification
The properties assume three things about the environment:
- memory raises `mem_rvalid` only while a read is outstanding, and never in the cycle of the request itself;
- `root_base` is page aligned;
- a start is meaningful only when the walker is idle.

The bench memory model answers each request one to three cycles after it is seen, and it serves only addresses it has been asked for. The bench builds page-aligned table chains, and it deliberately pulses start during a walk to show that the strobe is ignored.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int IDX_W  = 9;
    localparam int PG_SH  = 12;
    localparam int ENT_W  = 64;
    localparam int B_PRES = 0;
    localparam int B_LRG  = 7;
    localparam logic [2:0] ACC_INIT = 3'b110;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_FETCH = 2'd1,
        WS_WAIT  = 2'd2
    } wstate_e;

    typedef enum logic [1:0] {
        EV_NEXT    = 2'd0,
        EV_LEAF    = 2'd1,
        EV_NOTPRES = 2'd2,
        EV_RSVD    = 2'd3
    } ev_kind_e;

    typedef struct packed {
        logic rsvd;
        logic user;
        logic wr;
        logic prot;
    } pf_code_t;

    function automatic pf_code_t mk_code(input logic rsvd, input logic wr);
        pf_code_t c;
        c.rsvd = rsvd;
        c.user = 1'b0;
        c.wr   = wr;
        c.prot = rsvd;
        return c;
    endfunction

endpackage

// File: rtl/ptw_idx.sv
module ptw_idx
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int PA_W   = 52,
    parameter int VA_W   = PG_SH + IDX_W * LEVELS,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  va,
    input  logic [LVL_W-1:0] lvl,
    output logic [PA_W-1:0]  ent_addr
);

    logic [IDX_W-1:0] slice [LEVELS];
    logic [IDX_W-1:0] sel;
    logic             unused_lo;

    assign unused_lo = ^va[PG_SH-1:0];

    for (genvar g = 0; g < LEVELS; g++) begin : g_slice
        assign slice[g] = va[PG_SH + IDX_W*g +: IDX_W];
    end

    always_comb begin
        sel = '0;
        for (int l = 0; l < LEVELS; l++) begin
            if (lvl == LVL_W'(l)) sel = slice[l];
        end
    end

    assign ent_addr = base + PA_W'({sel, 3'b000});

endmodule

// File: rtl/ptw_eval.sv
module ptw_eval
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int PA_W   = 52,
    parameter int VA_W   = PG_SH + IDX_W * LEVELS,
    parameter int LVL_W  = $clog2(LEVELS)
) (
    input  logic [ENT_W-1:0] entry,
    input  logic [LVL_W-1:0] lvl,
    input  logic [VA_W-1:0]  omask,
    input  logic [VA_W-1:0]  va,
    input  logic             big_en,
    output ev_kind_e         kind,
    output logic [PA_W-1:0]  frame
);

    localparam logic [PA_W-1:0] TBL_MSK = {{(PA_W-PG_SH){1'b1}}, {PG_SH{1'b0}}};
    localparam logic [PA_W-1:0] LG_MSK  = {{(PA_W-PG_SH-1){1'b1}}, {(PG_SH+1){1'b0}}};

    logic [PA_W-1:0] raw;
    logic [PA_W-1:0] lg_frame;
    logic [PA_W-1:0] mask_pa;
    logic [PA_W-1:0] page_sel;
    logic            misalign;
    logic            lvl_ok;
    logic            unused_hi;

    assign raw       = entry[PA_W-1:0];
    assign unused_hi = ^entry[ENT_W-1:PA_W];
    assign lg_frame  = raw & LG_MSK;
    assign mask_pa   = PA_W'(omask);
    assign page_sel  = PA_W'(va & omask) & TBL_MSK;
    assign misalign  = |(lg_frame & mask_pa);
    assign lvl_ok    = (lvl == LVL_W'(1)) || ((lvl == LVL_W'(2)) && big_en);

    always_comb begin
        kind  = EV_NEXT;
        frame = raw & TBL_MSK;
        if (!entry[B_PRES]) begin
            kind  = EV_NOTPRES;
            frame = '0;
        end else if (lvl == '0) begin
            kind  = EV_LEAF;
        end else if (entry[B_LRG]) begin
            if (!lvl_ok || misalign) begin
                kind  = EV_RSVD;
                frame = '0;
            end else begin
                kind  = EV_LEAF;
                frame = lg_frame + page_sel;
            end
        end
    end

endmodule

// File: rtl/ptw_top.sv
module ptw_top
    import ptw_pkg::*;
#(
    parameter int LEVELS = 4,
    parameter int PA_W   = 52,
    parameter int VA_W   = PG_SH + IDX_W * LEVELS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [PA_W-1:0]  root_base,
    input  logic [VA_W-1:0]  lin_addr,
    input  logic             is_write,
    input  logic             big_en,
    output logic             mem_req,
    output logic [PA_W-1:0]  mem_addr,
    input  logic             mem_rvalid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             done,
    output logic             fault,
    output logic [3:0]       fault_code,
    output logic [PA_W-1:0]  phys_addr,
    output logic [VA_W-1:0]  offset_mask,
    output logic [2:0]       access
);

    localparam int LVL_W = $clog2(LEVELS);

    wstate_e          st;
    logic [LVL_W-1:0] lvl_q;
    logic [PA_W-1:0]  base_q;
    logic [VA_W-1:0]  mask_q;
    logic [VA_W-1:0]  mask_cur;
    logic [VA_W-1:0]  va_q;
    logic             wr_q;
    logic             en_q;
    logic [2:0]       acc_q;
    logic [2:0]       run_acc;
    ev_kind_e         kind;
    logic [PA_W-1:0]  frame;
    pf_code_t         code_q;

    assign mask_cur = mask_q >> IDX_W;
    assign run_acc  = acc_q & mem_rdata[2:0];
    assign mem_req  = (st == WS_FETCH);

    ptw_idx #(.LEVELS(LEVELS), .PA_W(PA_W), .VA_W(VA_W), .LVL_W(LVL_W)) u_idx (
        .base     (base_q),
        .va       (va_q),
        .lvl      (lvl_q),
        .ent_addr (mem_addr)
    );

    ptw_eval #(.LEVELS(LEVELS), .PA_W(PA_W), .VA_W(VA_W), .LVL_W(LVL_W)) u_eval (
        .entry  (mem_rdata),
        .lvl    (lvl_q),
        .omask  (mask_cur),
        .va     (va_q),
        .big_en (en_q),
        .kind   (kind),
        .frame  (frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= WS_IDLE;
            lvl_q       <= '0;
            base_q      <= '0;
            mask_q      <= '0;
            va_q        <= '0;
            wr_q        <= 1'b0;
            en_q        <= 1'b0;
            acc_q       <= '0;
            done        <= 1'b0;
            fault       <= 1'b0;
            code_q      <= '0;
            phys_addr   <= '0;
            offset_mask <= '0;
            access      <= '0;
        end else begin
            done <= 1'b0;
            unique case (st)
                WS_IDLE: begin
                    if (start) begin
                        va_q   <= lin_addr;
                        wr_q   <= is_write;
                        en_q   <= big_en;
                        base_q <= root_base;
                        lvl_q  <= LVL_W'(LEVELS - 1);
                        mask_q <= '1;
                        acc_q  <= ACC_INIT;
                        st     <= WS_FETCH;
                    end
                end
                WS_FETCH: st <= WS_WAIT;
                WS_WAIT: begin
                    if (mem_rvalid) begin
                        unique case (kind)
                            EV_NEXT: begin
                                base_q <= frame;
                                lvl_q  <= lvl_q - LVL_W'(1);
                                mask_q <= mask_cur;
                                acc_q  <= run_acc;
                                st     <= WS_FETCH;
                            end
                            EV_LEAF: begin
                                phys_addr   <= frame;
                                offset_mask <= mask_cur;
                                access      <= run_acc;
                                fault       <= 1'b0;
                                code_q      <= '0;
                                done        <= 1'b1;
                                st          <= WS_IDLE;
                            end
                            EV_NOTPRES: begin
                                fault  <= 1'b1;
                                code_q <= mk_code(1'b0, wr_q);
                                done   <= 1'b1;
                                st     <= WS_IDLE;
                            end
                            default: begin
                                fault  <= 1'b1;
                                code_q <= mk_code(1'b1, wr_q);
                                done   <= 1'b1;
                                st     <= WS_IDLE;
                            end
                        endcase
                    end
                end
                default: st <= WS_IDLE;
            endcase
        end
    end

    assign fault_code = code_q;

endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
    parameter int LEVELS = 4,
    parameter int PA_W   = 52,
    parameter int VA_W   = 12 + 9 * LEVELS
) (
    input logic            clk,
    input logic            rst,
    input logic            start,
    input logic            mem_req,
    input logic [PA_W-1:0] mem_addr,
    input logic            mem_rvalid,
    input logic            done,
    input logic            fault,
    input logic [3:0]      fault_code,
    input logic [PA_W-1:0] phys_addr,
    input logic [VA_W-1:0] offset_mask
);

    logic pend;
    logic busy;
    logic unused_bits;

    assign unused_bits = ^fault_code[2:1];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0;
            busy <= 1'b0;
        end else begin
            if (mem_req)         pend <= 1'b1;
            else if (mem_rvalid) pend <= 1'b0;
            if (start && (!busy || done)) busy <= 1'b1;
            else if (done)                busy <= 1'b0;
        end
    end

    p_addr_align_r2: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> !pend);

    p_req_when_busy_r12: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_np_flags_r4: assert property (@(posedge clk) disable iff (rst)
        (done && fault && !fault_code[0]) |-> !fault_code[3]);

    p_rsvd_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (done && fault && fault_code[3]) |-> fault_code[0]);

    p_page_align_r5: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (phys_addr[11:0] == 12'h000));

    p_mask_shape_r6: assert property (@(posedge clk) disable iff (rst)
        (done && !fault) |-> (($countones({1'b0, offset_mask} + (VA_W+1)'(1)) == 1)
                              && (&offset_mask[11:0])));

    p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_after_data_r11: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(mem_rvalid));

endmodule

bind ptw_top ptw_chk #(.LEVELS(LEVELS), .PA_W(PA_W), .VA_W(VA_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .mem_rvalid  (mem_rvalid),
    .done        (done),
    .fault       (fault),
    .fault_code  (fault_code),
    .phys_addr   (phys_addr),
    .offset_mask (offset_mask)
);

// File: tb/ptw_top_tb.sv
`timescale 1ns/1ps
module ptw_top_tb;

    localparam int PA_W = 52;
    localparam int VA_W = 48;
    localparam logic [63:0] TMSK = 64'h000f_ffff_ffff_f000;
    localparam logic [63:0] LMSK = 64'h000f_ffff_ffff_e000;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic [PA_W-1:0] root_base = '0;
    logic [VA_W-1:0] lin_addr = '0;
    logic            is_write = 1'b0;
    logic            big_en = 1'b0;
    logic            mem_req;
    logic [PA_W-1:0] mem_addr;
    logic            mem_rvalid = 1'b0;
    logic [63:0]     mem_rdata = '0;
    logic            done;
    logic            fault;
    logic [3:0]      fault_code;
    logic [PA_W-1:0] phys_addr;
    logic [VA_W-1:0] offset_mask;
    logic [2:0]      access;

    always #2.5 clk = ~clk;

    ptw_top u_dut (
        .clk(clk), .rst(rst), .start(start), .root_base(root_base),
        .lin_addr(lin_addr), .is_write(is_write), .big_en(big_en),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .fault_code(fault_code), .phys_addr(phys_addr),
        .offset_mask(offset_mask), .access(access)
    );

    logic [63:0] mem [logic [63:0]];
    logic [63:0] exp_addr_q [$];
    logic [63:0] alloc = 64'h0010_0000;

    int          vec_n = 0;
    int          bad_n = 0;
    int          rsp_cnt = 0;
    int          rsp_delay = 1;
    bit          pending = 0;
    bit          arm_done = 0;
    bit          walk_over = 0;
    logic [63:0] rsp_addr;
    bit          exp_fault;
    logic [3:0]  exp_code;
    logic [63:0] exp_pa;
    logic [63:0] exp_om;
    logic [2:0]  exp_acc;
    string       cur_tag = "R1";

    function automatic logic [63:0] rd(input logic [63:0] a);
        if (mem.exists(a)) return mem[a];
        return 64'h0;
    endfunction

    function automatic logic [63:0] idx_of(input logic [63:0] va, input int l);
        return (va >> (9 + 9*l)) & 64'hff8;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        vec_n++;
        if (!ok) begin
            bad_n++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    // behavioural reference walk over the bench memory
    task automatic ref_walk(input logic [63:0] root, input logic [63:0] va,
                            input bit rw, input bit en);
        logic [63:0] b, e, f, a;
        logic [63:0] msk;
        logic [2:0]  acc;
        bit          fin;
        b = root; msk = 64'h0000_ffff_ffff_ffff; acc = 3'b110; fin = 0;
        exp_addr_q.delete();
        exp_fault = 0; exp_code = 4'h0; exp_pa = 0; exp_om = 0;
        for (int l = 3; l >= 0; l--) begin
            if (!fin) begin
                a = b + idx_of(va, l);
                exp_addr_q.push_back(a);
                e = rd(a);
                msk = msk >> 9;
                acc = acc & e[2:0];
                if (!e[0]) begin
                    exp_fault = 1; exp_code = {1'b0, 1'b0, rw, 1'b0}; fin = 1;
                end else if (l == 0) begin
                    exp_pa = e & TMSK; exp_om = 64'hfff; fin = 1;
                end else if (e[7]) begin
                    f = e & LMSK;
                    if (l == 3 || (l == 2 && !en) || ((f & msk) != 0)) begin
                        exp_fault = 1; exp_code = {1'b1, 1'b0, rw, 1'b1};
                    end else begin
                        exp_pa = f + (va & msk & ~64'hfff); exp_om = msk;
                    end
                    fin = 1;
                end else begin
                    b = e & TMSK;
                end
            end
        end
        exp_acc = acc;
    endtask

    task automatic new_page(output logic [63:0] p);
        p = alloc;
        alloc = alloc + 64'h1000;
    endtask

    // build a chain of tables from root down to leaf_lvl, leaf entry given
    task automatic map(input logic [63:0] root, input logic [63:0] va,
                       input int leaf_lvl, input logic [63:0] leaf);
        logic [63:0] b, nb;
        b = root;
        for (int l = 3; l > leaf_lvl; l--) begin
            new_page(nb);
            mem[b + idx_of(va, l)] = nb | 64'h7;
            b = nb;
        end
        mem[b + idx_of(va, leaf_lvl)] = leaf;
    endtask

    always @(negedge clk) begin
        if (!rst) begin
            if (arm_done) begin
                arm_done = 0;
                chk(done == 1'b1, "R11", "done after last data", {63'h0, done}, 64'h1);
                chk(fault == exp_fault, cur_tag, "fault", {63'h0, fault}, {63'h0, exp_fault});
                if (exp_fault) begin
                    chk(fault_code == exp_code, cur_tag, "fault_code",
                        {60'h0, fault_code}, {60'h0, exp_code});
                end else begin
                    chk(64'(phys_addr) == exp_pa, cur_tag, "phys_addr", 64'(phys_addr), exp_pa);
                    chk(64'(offset_mask) == exp_om, cur_tag, "offset_mask", 64'(offset_mask), exp_om);
                    chk(access == exp_acc, "R10", "access", {61'h0, access}, {61'h0, exp_acc});
                end
                walk_over = 1;
            end else begin
                chk(done == 1'b0, "R11", "done idle", {63'h0, done}, 64'h0);
            end
            mem_rvalid = 1'b0;
            if (pending) begin
                if (rsp_cnt > 1) rsp_cnt--;
                else begin
                    mem_rvalid = 1'b1;
                    mem_rdata  = rd(rsp_addr);
                    pending    = 0;
                    if (exp_addr_q.size() == 0) arm_done = 1;
                end
            end
            if (mem_req) begin
                chk(!pending, "R3", "request while outstanding", 64'h1, 64'h0);
                if (exp_addr_q.size() == 0) begin
                    chk(0, "R12", "unexpected read", 64'(mem_addr), 64'h0);
                end else begin
                    logic [63:0] ea;
                    ea = exp_addr_q.pop_front();
                    chk(64'(mem_addr) == ea, "R2", "entry address", 64'(mem_addr), ea);
                end
                rsp_addr = 64'(mem_addr);
                rsp_cnt  = rsp_delay;
                pending  = 1;
            end
        end
    end

    task automatic run(input logic [63:0] root, input logic [63:0] va, input bit rw,
                       input bit en, input int dly, input bit poke, input string tag);
        int t;
        ref_walk(root, va, rw, en);
        cur_tag = tag; rsp_delay = dly; walk_over = 0;
        @(posedge clk); #1;
        root_base = root[PA_W-1:0]; lin_addr = va[VA_W-1:0];
        is_write = rw; big_en = en; start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        if (poke) begin
            repeat (3) @(posedge clk);
            #1; lin_addr = ~lin_addr; is_write = ~rw; start = 1'b1;
            @(posedge clk); #1; start = 1'b0;
        end
        t = 0;
        while (!walk_over && t < 2000) begin
            @(posedge clk); t++;
        end
        if (!walk_over) chk(0, tag, "walk timeout", 64'h0, 64'h1);
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad_n++;
        $display("FAIL R11 watchdog: actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

    initial begin
        logic [63:0] r;
        logic [63:0] va;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", {63'h0, mem_req}, 64'h0);
        chk(done == 1'b0, "R1", "done after reset", {63'h0, done}, 64'h0);
        chk(fault == 1'b0, "R1", "fault after reset", {63'h0, fault}, 64'h0);

        // R5: 4 KiB page, high entry bits ignored
        new_page(r); va = 64'h0000_5a5a_1234_5678;
        map(r, va, 0, 64'h8000_0000_abcd_e007);
        run(r, va, 1'b0, 1'b0, 1, 1'b0, "R5");

        // R5: bit 7 at level 0 is still a 4 KiB page
        new_page(r); va = 64'h0000_7fff_ffff_f123;
        map(r, va, 0, 64'h0000_0123_4567_8087);
        run(r, va, 1'b1, 1'b1, 2, 1'b0, "R5");

        // R10: read-only supervisor leaf clears access bits
        new_page(r); va = 64'h0000_0000_0040_3000;
        map(r, va, 0, 64'h0000_0000_0055_5001);
        run(r, va, 1'b1, 1'b0, 3, 1'b0, "R10");

        // R6: 2 MiB page
        new_page(r); va = 64'h0000_1357_9bdf_2468;
        map(r, va, 1, 64'h0000_0004_0020_0087);
        run(r, va, 1'b0, 1'b0, 1, 1'b0, "R6");

        // R6: bit 12 of a 2 MiB entry is discarded
        new_page(r); va = 64'h0000_0246_8ace_1357;
        map(r, va, 1, 64'h0000_0004_0020_1087);
        run(r, va, 1'b1, 1'b0, 2, 1'b0, "R6");

        // R9: misaligned 2 MiB frame
        new_page(r); va = 64'h0000_0011_2233_4455;
        map(r, va, 1, 64'h0000_0004_0020_4087);
        run(r, va, 1'b1, 1'b0, 1, 1'b0, "R9");

        // R7: 1 GiB page enabled
        new_page(r); va = 64'h0000_4321_8765_4321;
        map(r, va, 2, 64'h0000_0008_4000_0087);
        run(r, va, 1'b0, 1'b1, 2, 1'b0, "R7");

        // R7: 1 GiB page disabled -> reserved fault
        new_page(r); va = 64'h0000_4321_8765_4321;
        map(r, va, 2, 64'h0000_0008_4000_0087);
        run(r, va, 1'b0, 1'b0, 1, 1'b0, "R7");

        // R9: misaligned 1 GiB frame
        new_page(r); va = 64'h0000_0abc_def0_1234;
        map(r, va, 2, 64'h0000_0008_4010_0087);
        run(r, va, 1'b0, 1'b1, 3, 1'b0, "R9");

        // R8: large bit at the top level
        new_page(r); va = 64'h0000_8000_0000_0000;
        map(r, va, 3, 64'h0000_8000_0000_0087);
        run(r, va, 1'b1, 1'b1, 1, 1'b0, "R8");

        // R4: not present at level 1, write access
        new_page(r); va = 64'h0000_3333_4444_5555;
        map(r, va, 1, 64'h0000_0000_1234_5006);
        run(r, va, 1'b1, 1'b1, 2, 1'b0, "R4");

        // R4: not present at the top level, read access
        new_page(r); va = 64'h0000_6666_7777_8888;
        run(r, va, 1'b0, 1'b0, 1, 1'b0, "R4");

        // R12: start during a walk is ignored
        new_page(r); va = 64'h0000_0102_0304_0506;
        map(r, va, 0, 64'h0000_0000_0bad_c007);
        run(r, va, 1'b0, 1'b0, 1, 1'b1, "R12");

        // R11: back-to-back walk after the poked one completes cleanly
        run(r, va, 1'b1, 1'b0, 1, 1'b0, "R11");

        $display("== %0d vectors applied, %0d miscompares ==", vec_n, bad_n);
        $finish;
    end

endmodule